// File: doc/BRIEF.md
# Processor debug event controller

This block sits next to a simple CPU core and decides which debug events count. The core and its address comparators deliver one strobe per event kind each cycle: instruction completion, taken branch, interrupt taken (with a flag marking it critical), trap, a set of instruction-address matches and a set of data-address matches. Each data match carries a load/store tag. The block compares these strobes against a software-written control register and the core's global debug-enable bit.

Events that pass the control register are logged in a sticky status register. Software clears that register by writing ones. The block raises a level debug interrupt request for a new qualified event, and also while logged events remain pending. Software can also request a core-only hard reset through a two-bit field of the control register. The field clears itself one cycle after it is written.

Both registers sit behind a small synchronous register port. Writes take effect at the clock edge and reads are combinational from the address. Bits are numbered big-endian: bit 32 is the most significant bit of the 32-bit word, so bit n is held at little-endian index 63−n.

Top module: `dbg_evt_ctrl`

## Requirements
- R1: After reset the control register (address 0) and the status register (address 1) both read zero, and dbg_irq and core_hrst are low. Any other address reads zero.
- R2: The control register holds the following fields. Every other bit reads zero and ignores writes.
  - Bit 32: debug mode.
  - Bits 34:35: reset field, with bit 34 as its leading bit.
  - Bit 40: completion enable.
  - Bit 41: branch enable.
  - Bit 42: interrupt-taken enable.
  - Bit 43: trap enable.
  - Bits 48+i: enable for instruction match i.
  - Bits 52+2i and 53+2i: the mode field of data channel i, with 52+2i as its upper bit.
- R3: While the debug mode bit is 0, no event is recorded in the status register and dbg_irq stays low.
- R4: Completion, branch, trap and each instruction match have a one-bit enable, and an event whose enable is 0 is never generated. When debug mode is 1, a generated event sets its status bit at the next clock edge. The status bits are at bit 40 for completion, bit 41 for branch, bit 42 for interrupt taken, bit 43 for trap, bit 48+i for instruction match i and bit 52+i for data channel i.
- R5: Completion and branch events are never generated while msr_de is 0.
- R6: An interrupt-taken event is generated only when ev_irq_critical is 0 and its enable is set.
- R7: A data channel's two-bit mode decides when a match on that channel generates an event:
  - 00: never.
  - 01: only when the access is a store (ev_dac_store = 1).
  - 10: only when the access is a load (ev_dac_store = 0).
  - 11: on any access.
- R8: dbg_irq is high in the same cycle whenever debug mode and msr_de are both 1 and either a generated event is present or the status register is nonzero. At all other times it is low.
- R9: Status bits are sticky. A status write clears exactly the bits written as one. An event arriving in the same cycle as the clearing write leaves its bit set.
- R10: If events stay logged while msr_de is 0, dbg_irq reasserts as soon as msr_de returns to 1, with no new event.
- R11: A write whose reset field has a leading 1 drives core_hrst high for exactly the cycle after the write, provided debug mode (as written) and msr_de are both 1 in that cycle. A leading 0, or either gate at 0, gives no pulse.
- R12: The reset field reads back the written value in the cycle after the write and reads 00 from the following cycle, unless it is written again.
- R13: At the clock edge that ends a core_hrst pulse, the control and status registers both become zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msr_de | input | 1 | Global debug-enable bit of the core |
| reg_addr | input | ADDR_W | Register address: 0 selects control, 1 selects status |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| ev_complete | input | 1 | Instruction completed this cycle |
| ev_branch | input | 1 | Branch taken this cycle |
| ev_irq_taken | input | 1 | Interrupt taken this cycle |
| ev_irq_critical | input | 1 | The interrupt taken this cycle is critical |
| ev_trap | input | 1 | Trap condition this cycle |
| ev_iac | input | NUM_IAC | Instruction address match per channel |
| ev_dac_hit | input | NUM_DAC | Data address match per channel |
| ev_dac_store | input | NUM_DAC | Access type per data channel: 1 store, 0 load |
| dbg_irq | output | 1 | Debug interrupt request (level) |
| core_hrst | output | 1 | Core-only hard reset pulse |

## Verification
The bench builds the block with its defaults: NUM_IAC = 2, NUM_DAC = 2 and ADDR_W = 2. With six single-bit event kinds in this configuration, it can apply all 64 enable settings against all 64 strobe patterns, each with both msr_de levels and both critical-flag levels. It can also apply every pair of data-channel modes against every combination of match and load/store tag on both channels. The reset-field cases cover each gate combination directly, including a pulse that wipes pending status.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

    localparam int REG_W = 32;

    // little-endian indices; big-endian bit n sits at index 63-n
    localparam int IDM_IDX      = 31;  // bit 32
    localparam int RST_HI_IDX   = 29;  // bit 34, leading bit
    localparam int RST_LO_IDX   = 28;  // bit 35
    localparam int CMP_IDX      = 23;  // bit 40
    localparam int BRT_IDX      = 22;  // bit 41
    localparam int IRQ_IDX      = 21;  // bit 42
    localparam int TRAP_IDX     = 20;  // bit 43
    localparam int IAC_BASE_IDX = 15;  // bit 48, up to 4 channels
    localparam int DAC_BASE_IDX = 11;  // bit 52, up to 4 channels

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;

    localparam logic [REG_W-1:0] ONE_W = REG_W'(1);

    function automatic logic [REG_W-1:0] ctrl_mask(input int n_iac, input int n_dac);
        logic [REG_W-1:0] m;
        m = (ONE_W << IDM_IDX) | (ONE_W << RST_HI_IDX) | (ONE_W << RST_LO_IDX)
          | (ONE_W << CMP_IDX) | (ONE_W << BRT_IDX) | (ONE_W << IRQ_IDX)
          | (ONE_W << TRAP_IDX);
        for (int i = 0; i < n_iac; i++) m = m | (ONE_W << (IAC_BASE_IDX - i));
        for (int i = 0; i < 2 * n_dac; i++) m = m | (ONE_W << (DAC_BASE_IDX - i));
        return m;
    endfunction

    function automatic logic [REG_W-1:0] stat_mask(input int n_iac, input int n_dac);
        logic [REG_W-1:0] m;
        m = (ONE_W << CMP_IDX) | (ONE_W << BRT_IDX) | (ONE_W << IRQ_IDX)
          | (ONE_W << TRAP_IDX);
        for (int i = 0; i < n_iac; i++) m = m | (ONE_W << (IAC_BASE_IDX - i));
        for (int i = 0; i < n_dac; i++) m = m | (ONE_W << (DAC_BASE_IDX - i));
        return m;
    endfunction

    localparam logic [REG_W-1:0] RST_FIELD = (ONE_W << RST_HI_IDX) | (ONE_W << RST_LO_IDX);

endpackage

// File: rtl/dbg_ctl_regs.sv
module dbg_ctl_regs
    import dbg_evt_pkg::*;
#(
    parameter int NUM_IAC = 2,
    parameter int NUM_DAC = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_W-1:0]      wdata,
    input  logic                  hrst,
    output logic [REG_W-1:0]      ctrl_word,
    output logic                  idm,
    output logic                  rst_lead,
    output logic                  en_cmp,
    output logic                  en_brt,
    output logic                  en_irq,
    output logic                  en_trap,
    output logic [NUM_IAC-1:0]    iac_en,
    output logic [2*NUM_DAC-1:0]  dac_mode
);

    localparam logic [REG_W-1:0] MASK = ctrl_mask(NUM_IAC, NUM_DAC);

    typedef struct packed {
        logic [REG_W-1:0] word;
    } ctl_state_t;

    ctl_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        // the reset request lives for one cycle only
        state_d.word = state_q.word & ~RST_FIELD;
        if (wr_en) begin
            state_d.word = wdata & MASK;
        end
        if (hrst) begin
            state_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_word = state_q.word;
    assign idm       = state_q.word[IDM_IDX];
    assign rst_lead  = state_q.word[RST_HI_IDX];
    assign en_cmp    = state_q.word[CMP_IDX];
    assign en_brt    = state_q.word[BRT_IDX];
    assign en_irq    = state_q.word[IRQ_IDX];
    assign en_trap   = state_q.word[TRAP_IDX];

    for (genvar g = 0; g < NUM_IAC; g++) begin : g_iac_en
        assign iac_en[g] = state_q.word[IAC_BASE_IDX - g];
    end

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac_mode
        assign dac_mode[2*g+1] = state_q.word[DAC_BASE_IDX - 2*g];      // load enable
        assign dac_mode[2*g]   = state_q.word[DAC_BASE_IDX - 2*g - 1];  // store enable
    end

endmodule

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual
    import dbg_evt_pkg::*;
#(
    parameter int NUM_IAC = 2,
    parameter int NUM_DAC = 2
) (
    input  logic                  msr_de,
    input  logic                  en_cmp,
    input  logic                  en_brt,
    input  logic                  en_irq,
    input  logic                  en_trap,
    input  logic [NUM_IAC-1:0]    iac_en,
    input  logic [2*NUM_DAC-1:0]  dac_mode,
    input  logic                  ev_complete,
    input  logic                  ev_branch,
    input  logic                  ev_irq_taken,
    input  logic                  ev_irq_critical,
    input  logic                  ev_trap,
    input  logic [NUM_IAC-1:0]    ev_iac,
    input  logic [NUM_DAC-1:0]    ev_dac_hit,
    input  logic [NUM_DAC-1:0]    ev_dac_store,
    output logic [REG_W-1:0]      hit_word
);

    logic [NUM_DAC-1:0] dac_ok;

    for (genvar g = 0; g < NUM_DAC; g++) begin : g_dac_qual
        assign dac_ok[g] = ev_dac_hit[g]
                         & (ev_dac_store[g] ? dac_mode[2*g] : dac_mode[2*g+1]);
    end

    always_comb begin
        hit_word           = '0;
        hit_word[CMP_IDX]  = ev_complete & en_cmp & msr_de;
        hit_word[BRT_IDX]  = ev_branch & en_brt & msr_de;
        hit_word[IRQ_IDX]  = ev_irq_taken & ~ev_irq_critical & en_irq;
        hit_word[TRAP_IDX] = ev_trap & en_trap;
        for (int i = 0; i < NUM_IAC; i++) begin
            hit_word = hit_word
                     | ({{(REG_W-1){1'b0}}, ev_iac[i] & iac_en[i]} << (IAC_BASE_IDX - i));
        end
        for (int i = 0; i < NUM_DAC; i++) begin
            hit_word = hit_word
                     | ({{(REG_W-1){1'b0}}, dac_ok[i]} << (DAC_BASE_IDX - i));
        end
    end

endmodule

// File: rtl/dbg_status.sv
module dbg_status
    import dbg_evt_pkg::*;
#(
    parameter int NUM_IAC = 2,
    parameter int NUM_DAC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idm,
    input  logic [REG_W-1:0]  hit_word,
    input  logic [REG_W-1:0]  clr_word,
    input  logic              hrst,
    output logic [REG_W-1:0]  stat_word,
    output logic              pending
);

    localparam logic [REG_W-1:0] MASK = stat_mask(NUM_IAC, NUM_DAC);

    typedef struct packed {
        logic [REG_W-1:0] word;
    } st_state_t;

    st_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        // clear first, then set: a fresh event survives a same-cycle clear
        state_d.word = (state_q.word & ~clr_word) | (idm ? hit_word : '0);
        state_d.word = state_d.word & MASK;
        if (hrst) begin
            state_d.word = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_word = state_q.word;
    assign pending   = |state_q.word;

endmodule

// File: rtl/dbg_evt_ctrl.sv
module dbg_evt_ctrl
    import dbg_evt_pkg::*;
#(
    parameter int NUM_IAC = 2,
    parameter int NUM_DAC = 2,
    parameter int ADDR_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                msr_de,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                ev_complete,
    input  logic                ev_branch,
    input  logic                ev_irq_taken,
    input  logic                ev_irq_critical,
    input  logic                ev_trap,
    input  logic [NUM_IAC-1:0]  ev_iac,
    input  logic [NUM_DAC-1:0]  ev_dac_hit,
    input  logic [NUM_DAC-1:0]  ev_dac_store,
    output logic                dbg_irq,
    output logic                core_hrst
);

    logic                 wr_ctrl, wr_stat;
    logic [REG_W-1:0]     clr_word;
    logic [REG_W-1:0]     ctrl_word, stat_word, hit_word;
    logic                 idm, rst_lead, en_cmp, en_brt, en_irq, en_trap;
    logic [NUM_IAC-1:0]   iac_en;
    logic [2*NUM_DAC-1:0] dac_mode;
    logic                 stat_pending;

    assign wr_ctrl  = reg_we && (reg_addr == ADDR_W'(ADDR_CTRL));
    assign wr_stat  = reg_we && (reg_addr == ADDR_W'(ADDR_STAT));
    assign clr_word = wr_stat ? reg_wdata : '0;

    dbg_ctl_regs #(.NUM_IAC(NUM_IAC), .NUM_DAC(NUM_DAC)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_ctrl),
        .wdata     (reg_wdata),
        .hrst      (core_hrst),
        .ctrl_word (ctrl_word),
        .idm       (idm),
        .rst_lead  (rst_lead),
        .en_cmp    (en_cmp),
        .en_brt    (en_brt),
        .en_irq    (en_irq),
        .en_trap   (en_trap),
        .iac_en    (iac_en),
        .dac_mode  (dac_mode)
    );

    dbg_evt_qual #(.NUM_IAC(NUM_IAC), .NUM_DAC(NUM_DAC)) u_qual (
        .msr_de          (msr_de),
        .en_cmp          (en_cmp),
        .en_brt          (en_brt),
        .en_irq          (en_irq),
        .en_trap         (en_trap),
        .iac_en          (iac_en),
        .dac_mode        (dac_mode),
        .ev_complete     (ev_complete),
        .ev_branch       (ev_branch),
        .ev_irq_taken    (ev_irq_taken),
        .ev_irq_critical (ev_irq_critical),
        .ev_trap         (ev_trap),
        .ev_iac          (ev_iac),
        .ev_dac_hit      (ev_dac_hit),
        .ev_dac_store    (ev_dac_store),
        .hit_word        (hit_word)
    );

    dbg_status #(.NUM_IAC(NUM_IAC), .NUM_DAC(NUM_DAC)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .idm       (idm),
        .hit_word  (hit_word),
        .clr_word  (clr_word),
        .hrst      (core_hrst),
        .stat_word (stat_word),
        .pending   (stat_pending)
    );

    assign core_hrst = rst_lead & idm & msr_de;
    assign dbg_irq   = idm & msr_de & (stat_pending | (|hit_word));

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(ADDR_CTRL)) begin
            reg_rdata = ctrl_word;
        end else if (reg_addr == ADDR_W'(ADDR_STAT)) begin
            reg_rdata = stat_word;
        end
    end

endmodule

// File: rtl/dbg_evt_ctrl_chk.sv
module dbg_evt_ctrl_chk
    import dbg_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             msr_de,
    input logic             wr_ctrl,
    input logic             wr_stat,
    input logic [REG_W-1:0] ctrl_word,
    input logic [REG_W-1:0] stat_word,
    input logic             dbg_irq,
    input logic             core_hrst
);

    // R3
    no_log_without_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_word[IDM_IDX] && !core_hrst) |=> ((stat_word & ~$past(stat_word)) == '0));

    // R3
    no_irq_without_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_irq |-> (ctrl_word[IDM_IDX] && msr_de));

    // R10
    pending_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[IDM_IDX] && msr_de && (stat_word != '0)) |-> dbg_irq);

    // R9
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_hrst && !wr_stat) |=> ((~stat_word & $past(stat_word)) == '0));

    // R11
    hrst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_hrst |=> !core_hrst);

    // R13
    hrst_clears_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_hrst |=> ((ctrl_word == '0) && (stat_word == '0)));

    // R12
    rst_field_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((ctrl_word & RST_FIELD) != '0) && !wr_ctrl) |=> ((ctrl_word & RST_FIELD) == '0));

endmodule

bind dbg_evt_ctrl dbg_evt_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .msr_de    (msr_de),
    .wr_ctrl   (wr_ctrl),
    .wr_stat   (wr_stat),
    .ctrl_word (ctrl_word),
    .stat_word (stat_word),
    .dbg_irq   (dbg_irq),
    .core_hrst (core_hrst)
);

// File: tb/dbg_evt_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_evt_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        msr_de;
    logic [1:0]  reg_addr;
    logic        reg_we;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        ev_complete, ev_branch, ev_irq_taken, ev_irq_critical, ev_trap;
    logic [1:0]  ev_iac, ev_dac_hit, ev_dac_store;
    logic        dbg_irq, core_hrst;

    int vectors = 0;
    int fails   = 0;

    always #4 clk = ~clk;

    dbg_evt_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .msr_de(msr_de),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_complete(ev_complete), .ev_branch(ev_branch), .ev_irq_taken(ev_irq_taken),
        .ev_irq_critical(ev_irq_critical), .ev_trap(ev_trap), .ev_iac(ev_iac),
        .ev_dac_hit(ev_dac_hit), .ev_dac_store(ev_dac_store),
        .dbg_irq(dbg_irq), .core_hrst(core_hrst)
    );

    // positions from the requirements: big-endian bit n at index 63-n
    localparam int P_IDM = 31, P_RH = 29, P_RL = 28;
    localparam int P_CMP = 23, P_BRT = 22, P_IRQ = 21, P_TRAP = 20;
    localparam int P_IAC0 = 15, P_IAC1 = 14;
    localparam int P_D0H = 11, P_D0L = 10, P_D1H = 9, P_D1L = 8;
    localparam int S_D0 = 11, S_D1 = 10;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick();
        reg_we    = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic idm, input logic [1:0] rf,
                                            input logic [5:0] en,
                                            input logic [1:0] d0, input logic [1:0] d1);
        logic [31:0] w;
        w = '0;
        w[P_IDM] = idm;  w[P_RH] = rf[1]; w[P_RL] = rf[0];
        w[P_CMP] = en[0]; w[P_BRT] = en[1]; w[P_IRQ] = en[2]; w[P_TRAP] = en[3];
        w[P_IAC0] = en[4]; w[P_IAC1] = en[5];
        w[P_D0H] = d0[1]; w[P_D0L] = d0[0]; w[P_D1H] = d1[1]; w[P_D1L] = d1[0];
        return w;
    endfunction

    function automatic logic [31:0] exp_hits(input logic [5:0] en, input logic [5:0] s,
                                             input logic de, input logic crit);
        logic [31:0] e;
        e = '0;
        e[P_CMP]  = s[0] & en[0] & de;
        e[P_BRT]  = s[1] & en[1] & de;
        e[P_IRQ]  = s[2] & en[2] & ~crit;
        e[P_TRAP] = s[3] & en[3];
        e[P_IAC0] = s[4] & en[4];
        e[P_IAC1] = s[5] & en[5];
        return e;
    endfunction

    function automatic logic dac_fires(input logic [1:0] mode, input logic hit, input logic st);
        return hit & (st ? mode[0] : mode[1]);
    endfunction

    task automatic strobes(input logic [5:0] s, input logic crit);
        ev_complete = s[0]; ev_branch = s[1]; ev_irq_taken = s[2];
        ev_trap = s[3]; ev_iac = s[5:4]; ev_irq_critical = crit;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] r, eh, ctrlw;
        rst_n = 1'b0; msr_de = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_wdata = '0;
        strobes('0, 1'b0); ev_dac_hit = '0; ev_dac_store = '0;
        repeat (3) tick();
        rd(2'd0, r); check("R1 ctrl", r, 32'h0);
        rd(2'd1, r); check("R1 stat", r, 32'h0);
        check("R1 irq", {31'd0, dbg_irq}, 32'h0);
        check("R1 hrst", {31'd0, core_hrst}, 32'h0);
        rst_n = 1'b1;
        tick();
        rd(2'd2, r); check("R1 unmapped", r, 32'h0);

        // R2 layout / reserved bits; R12 self clear
        msr_de = 1'b0;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, r); check("R2 ctrl mask", r, mk_ctrl(1'b1, 2'b11, 6'h3F, 2'b11, 2'b11));
        check("R11 no pulse de=0", {31'd0, core_hrst}, 32'h0);
        tick();
        rd(2'd0, r); check("R12 field cleared", r, mk_ctrl(1'b1, 2'b00, 6'h3F, 2'b11, 2'b11));

        // single-bit events: R3 R4 R5 R6 R8
        for (int m = 0; m < 2; m++) begin
            for (int en = 0; en < 64; en++) begin
                if (m == 0 && en != 63) continue;
                wr(2'd0, mk_ctrl(m[0], 2'b00, en[5:0], 2'b00, 2'b00));
                for (int s = 0; s < 64; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        msr_de = k[0];
                        wr(2'd1, 32'hFFFF_FFFF);
                        strobes(s[5:0], k[1]);
                        eh = exp_hits(en[5:0], s[5:0], k[0], k[1]);
                        #1;
                        check(m ? "R8 irq new event" : "R3 irq",
                              {31'd0, dbg_irq}, {31'd0, m[0] & k[0] & (eh != 0)});
                        tick();
                        strobes('0, 1'b0);
                        rd(2'd1, r);
                        check(m ? "R4/R5/R6 status" : "R3 status", r, m ? eh : 32'h0);
                        check("R8 irq pending", {31'd0, dbg_irq},
                              {31'd0, m[0] & k[0] & (eh != 0)});
                    end
                end
            end
        end

        // R7 data channel qualifiers
        msr_de = 1'b1;
        for (int m0 = 0; m0 < 4; m0++) begin
            for (int m1 = 0; m1 < 4; m1++) begin
                wr(2'd0, mk_ctrl(1'b1, 2'b00, 6'h00, m0[1:0], m1[1:0]));
                for (int h = 0; h < 4; h++) begin
                    for (int t = 0; t < 4; t++) begin
                        wr(2'd1, 32'hFFFF_FFFF);
                        ev_dac_hit = h[1:0]; ev_dac_store = t[1:0];
                        tick();
                        ev_dac_hit = '0; ev_dac_store = '0;
                        eh = '0;
                        eh[S_D0] = dac_fires(m0[1:0], h[0], t[0]);
                        eh[S_D1] = dac_fires(m1[1:0], h[1], t[1]);
                        rd(2'd1, r); check("R7 dac", r, eh);
                    end
                end
            end
        end

        // R9 sticky / W1C, R10 re-trigger
        msr_de = 1'b0;
        wr(2'd0, mk_ctrl(1'b1, 2'b00, 6'h0A, 2'b00, 2'b00)); // branch + trap enabled
        wr(2'd1, 32'hFFFF_FFFF);
        strobes(6'h08, 1'b0); tick(); strobes('0, 1'b0);
        repeat (3) tick();
        rd(2'd1, r); check("R9 sticky", r, 32'h1 << P_TRAP);
        check("R8 irq de=0", {31'd0, dbg_irq}, 32'h0);
        wr(2'd1, 32'h0000_0001 | (32'h1 << P_CMP));
        rd(2'd1, r); check("R9 partial clear", r, 32'h1 << P_TRAP);
        msr_de = 1'b1; #1;
        check("R10 retrigger", {31'd0, dbg_irq}, 32'h1);
        strobes(6'h08, 1'b0);
        wr(2'd1, 32'hFFFF_FFFF);
        strobes('0, 1'b0);
        rd(2'd1, r); check("R9 set beats clear", r, 32'h1 << P_TRAP);
        wr(2'd1, 32'h1 << P_TRAP);
        rd(2'd1, r); check("R9 clear", r, 32'h0);
        check("R10 irq drops", {31'd0, dbg_irq}, 32'h0);

        // R11 R13 reset field, leading 1 with both gates
        for (int v = 2; v < 4; v++) begin
            msr_de = 1'b1;
            wr(2'd1, 32'hFFFF_FFFF);
            strobes(6'h08, 1'b0); tick(); strobes('0, 1'b0);
            ctrlw = mk_ctrl(1'b1, v[1:0], 6'h0A, 2'b00, 2'b00);
            wr(2'd0, ctrlw);
            check("R11 pulse", {31'd0, core_hrst}, 32'h1);
            rd(2'd0, r); check("R12 readback", r, ctrlw);
            tick();
            check("R11 pulse ends", {31'd0, core_hrst}, 32'h0);
            rd(2'd0, r); check("R13 ctrl zero", r, 32'h0);
            rd(2'd1, r); check("R13 stat zero", r, 32'h0);
        end

        // R11 gating cases: leading 0; idm=0; de=0
        msr_de = 1'b1;
        ctrlw = mk_ctrl(1'b1, 2'b01, 6'h08, 2'b00, 2'b00);
        wr(2'd0, ctrlw);
        check("R11 leading 0", {31'd0, core_hrst}, 32'h0);
        rd(2'd0, r); check("R12 readback 01", r, ctrlw);
        tick();
        rd(2'd0, r); check("R12 cleared 01", r, mk_ctrl(1'b1, 2'b00, 6'h08, 2'b00, 2'b00));
        ctrlw = mk_ctrl(1'b0, 2'b10, 6'h08, 2'b00, 2'b00);
        wr(2'd0, ctrlw);
        check("R11 idm 0", {31'd0, core_hrst}, 32'h0);
        tick();
        rd(2'd0, r); check("R12 cleared idm0", r, mk_ctrl(1'b0, 2'b00, 6'h08, 2'b00, 2'b00));
        wr(2'd0, mk_ctrl(1'b1, 2'b00, 6'h08, 2'b00, 2'b00));
        msr_de = 1'b0;
        strobes(6'h08, 1'b0); tick(); strobes('0, 1'b0);
        wr(2'd0, mk_ctrl(1'b1, 2'b11, 6'h08, 2'b00, 2'b00));
        check("R11 de 0", {31'd0, core_hrst}, 32'h0);
        tick();
        rd(2'd1, r); check("R11 status kept", r, 32'h1 << P_TRAP);
        rd(2'd0, r); check("R11 ctrl kept", r, mk_ctrl(1'b1, 2'b00, 6'h08, 2'b00, 2'b00));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule